// File: doc/BRIEF.md
# Phase-Locked Numerically Controlled Oscillator with PI Loop Filter

This block is a fully digital phase-locked loop. An N-bit phase accumulator adds a steering word on every clock and wraps modulo 2^N. The carry out of that addition is a loop update event. At each update, the block compares the input phase word with the accumulator phase just after the wrap. It then runs a proportional-integral filter on the difference. The filter output plus a programmable nominal frequency offset becomes the next steering word.

The loop filter therefore runs once per oscillator cycle, not once per clock. Between wraps, the phase error and the integrator hold their values. Both gains are powers of two, given as right-shift amounts. The integrator and the filter output saturate at the signed limits of the integrator width. The steering word is clamped so that the oscillator can never stop or exceed the modulus. The wrap pulse, the accumulator phase, the phase error and the integrator are all brought out, so the loop's phase and frequency state can be watched directly.

Top module: `pi_nco_pll`

## Requirements
- R1: On every rising clock edge out of reset, `phase_o` becomes (`phase_o` + steering word) mod 2^ACC_W. The remainder is kept after a wrap. `wrap_o` is 1 for the one cycle that follows an addition that carried out of ACC_W bits, and 0 otherwise.
- R2: The steering word is the nominal offset `nominal_i` (unsigned) plus the stored filter correction. It is clamped to the range 1 to 2^ACC_W-1. Right after reset the correction is 0, so the first step equals `nominal_i`.
- R3: At each update, the phase error is (`phase_in_i` - post-wrap phase) mod 2^ACC_W, read as a signed two's-complement value. It appears on `perr_o` in the same cycle that `wrap_o` is 1, and it holds until the next update.
- R4: At each update, the integrator becomes the integrator plus (phase error >>> `ki_shift_i`), using an arithmetic shift. It holds between updates and is visible on `integ_o`.
- R5: The integrator saturates at -2^(INT_W-1) and 2^(INT_W-1)-1 instead of wrapping.
- R6: At each update, the correction becomes the updated integrator plus (phase error >>> `kp_shift_i`), saturated to INT_W bits. The new steering word is used from the next clock edge on.
- R7: While `rst_ni` is low, `phase_o`, `wrap_o`, `perr_o` and `integ_o` are all 0. Reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_in_i | input | ACC_W | Input phase word the loop tracks |
| nominal_i | input | ACC_W | Nominal steering offset (unsigned) |
| kp_shift_i | input | SHIFT_W | Proportional gain as a right-shift amount |
| ki_shift_i | input | SHIFT_W | Integral gain as a right-shift amount |
| wrap_o | output | 1 | One-cycle pulse marking a loop update |
| phase_o | output | ACC_W | Accumulator phase |
| perr_o | output | ACC_W | Signed phase error of the latest update |
| integ_o | output | INT_W | Signed integrator (frequency state) |

## Verification
`phase_o` changes on every rising edge. `wrap_o`, `perr_o` and `integ_o` all change on the edge where the addition carries, so they are valid together in the cycle that follows. A correction calculated on that edge first moves the phase on the edge after it. The bench advances an arithmetic model on each rising edge and compares all four outputs at the next falling edge. This gives exactly the one-edge latency of every register, and the steering delay shows up as the following phase step. For the saturation and clamp cases, the bench steers `phase_in_i` so that each update sees a chosen error. It then checks the saturated integrator value and the minimum step of 1 directly.

// File: rtl/pll_pkg.sv
package pll_pkg;
  typedef logic signed [63:0] wide_t;

  function automatic wide_t smax(input int unsigned w);
    return (64'sd1 <<< (w - 1)) - 64'sd1;
  endfunction

  function automatic wide_t smin(input int unsigned w);
    return -(64'sd1 <<< (w - 1));
  endfunction

  function automatic wide_t clamp(input wide_t x, input wide_t lo, input wide_t hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction
endpackage

// File: rtl/phase_acc.sv
module phase_acc #(
  parameter int unsigned ACC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] steer_i,
  output logic             carry_o,
  output logic [ACC_W-1:0] next_o,
  output logic [ACC_W-1:0] phase_o,
  output logic             wrap_o
);
  logic [ACC_W:0] sum;

  assign sum     = {1'b0, phase_o} + {1'b0, steer_i};
  assign carry_o = sum[ACC_W];
  assign next_o  = sum[ACC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      wrap_o  <= 1'b0;
    end else begin
      phase_o <= next_o;
      wrap_o  <= carry_o;
    end
  end

  // R1: after a carry the remainder is below the step; otherwise phase moved forward
  a_r1_wrap_remainder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> wrap_o && (phase_o < $past(steer_i)));
  a_r1_no_wrap_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_o |=> !wrap_o && (phase_o >= $past(steer_i)));
endmodule

// File: rtl/phase_det.sv
module phase_det #(
  parameter int unsigned ACC_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic [ACC_W-1:0]        phase_in_i,
  input  logic [ACC_W-1:0]        ref_i,
  output logic signed [ACC_W-1:0] err_o,
  output logic signed [ACC_W-1:0] perr_o
);
  // modulo difference, read signed: short way round the circle
  assign err_o = phase_in_i - ref_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    perr_o <= '0;
    else if (upd_i) perr_o <= err_o;
  end

  // R3: error only moves on an update event
  a_r3_perr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(perr_o));
endmodule

// File: rtl/pi_filter.sv
module pi_filter
  import pll_pkg::*;
#(
  parameter int unsigned ACC_W   = 12,
  parameter int unsigned INT_W   = 16,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  logic signed [ACC_W-1:0] err_i,
  input  logic [SHIFT_W-1:0]      kp_shift_i,
  input  logic [SHIFT_W-1:0]      ki_shift_i,
  input  logic [ACC_W-1:0]        nominal_i,
  output logic signed [INT_W-1:0] integ_o,
  output logic [ACC_W-1:0]        steer_o
);
  localparam wide_t INT_MAX   = smax(INT_W);
  localparam wide_t INT_MIN   = smin(INT_W);
  localparam wide_t STEER_MAX = (64'sd1 <<< ACC_W) - 64'sd1;

  logic signed [INT_W-1:0] corr_q;
  logic signed [INT_W-1:0] int_nx;
  logic signed [INT_W-1:0] corr_nx;

  assign int_nx  = INT_W'(clamp(64'(integ_o) + (64'(err_i) >>> ki_shift_i), INT_MIN, INT_MAX));
  assign corr_nx = INT_W'(clamp(64'(int_nx) + (64'(err_i) >>> kp_shift_i), INT_MIN, INT_MAX));
  // step never 0 so the loop keeps updating
  assign steer_o = ACC_W'(clamp(64'(nominal_i) + 64'(corr_q), 64'sd1, STEER_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_o <= '0;
      corr_q  <= '0;
    end else if (upd_i) begin
      integ_o <= int_nx;
      corr_q  <= corr_nx;
    end
  end

  // R4: integrator frozen between updates
  a_r4_integ_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(integ_o));
  // R2: steering word stays non-zero
  a_r2_steer_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer_o != '0);
endmodule

// File: rtl/pi_nco_pll.sv
module pi_nco_pll #(
  parameter int unsigned ACC_W   = 12,
  parameter int unsigned INT_W   = 16,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ACC_W-1:0]        phase_in_i,
  input  logic [ACC_W-1:0]        nominal_i,
  input  logic [SHIFT_W-1:0]      kp_shift_i,
  input  logic [SHIFT_W-1:0]      ki_shift_i,
  output logic                    wrap_o,
  output logic [ACC_W-1:0]        phase_o,
  output logic signed [ACC_W-1:0] perr_o,
  output logic signed [INT_W-1:0] integ_o
);
  logic                    carry;
  logic [ACC_W-1:0]        next_phase;
  logic [ACC_W-1:0]        steer;
  logic signed [ACC_W-1:0] err;

  phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .steer_i (steer),
    .carry_o (carry),
    .next_o  (next_phase),
    .phase_o (phase_o),
    .wrap_o  (wrap_o)
  );

  phase_det #(.ACC_W(ACC_W)) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (carry),
    .phase_in_i (phase_in_i),
    .ref_i      (next_phase),
    .err_o      (err),
    .perr_o     (perr_o)
  );

  pi_filter #(.ACC_W(ACC_W), .INT_W(INT_W), .SHIFT_W(SHIFT_W)) u_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (carry),
    .err_i      (err),
    .kp_shift_i (kp_shift_i),
    .ki_shift_i (ki_shift_i),
    .nominal_i  (nominal_i),
    .integ_o    (integ_o),
    .steer_o    (steer)
  );
endmodule

// File: tb/pi_nco_pll_tb.sv
module pi_nco_pll_tb;
  localparam int unsigned ACC_W   = 12;
  localparam int unsigned INT_W   = 16;
  localparam int unsigned SHIFT_W = 4;
  localparam longint MOD  = 64'sd1 << ACC_W;
  localparam longint IMAX = (64'sd1 << (INT_W - 1)) - 1;
  localparam longint IMIN = -(64'sd1 << (INT_W - 1));

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [ACC_W-1:0] phase_in = '0;
  logic [ACC_W-1:0] nominal = '0;
  logic [SHIFT_W-1:0] kp_sh = '0;
  logic [SHIFT_W-1:0] ki_sh = '0;
  logic wrap;
  logic [ACC_W-1:0] phase;
  logic signed [ACC_W-1:0] perr;
  logic signed [INT_W-1:0] integ;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pi_nco_pll #(.ACC_W(ACC_W), .INT_W(INT_W), .SHIFT_W(SHIFT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .phase_in_i(phase_in), .nominal_i(nominal),
    .kp_shift_i(kp_sh), .ki_shift_i(ki_sh), .wrap_o(wrap), .phase_o(phase),
    .perr_o(perr), .integ_o(integ)
  );

  // arithmetic model of the requirements
  longint m_ph, m_corr, m_int, m_err;
  bit m_wrap;

  function automatic longint lim(longint x, longint lo, longint hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  function automatic longint m_steer();
    return lim(longint'(nominal) + m_corr, 1, MOD - 1);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_corr = 0; m_int = 0; m_err = 0; m_wrap = 0;
    end else begin
      longint s, e;
      s = m_ph + m_steer();
      m_wrap = (s >= MOD);
      m_ph = s % MOD;
      if (m_wrap) begin
        e = (longint'(phase_in) - m_ph) & (MOD - 1);
        if (e >= MOD / 2) e = e - MOD;
        m_err = e;
        m_int = lim(m_int + (e >>> ki_sh), IMIN, IMAX);
        m_corr = lim(m_int + (e >>> kp_sh), IMIN, IMAX);
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R1 R2 R6 phase_o", longint'(phase), m_ph);
    chk("R1 wrap_o", longint'(wrap), longint'(m_wrap));
    chk("R3 perr_o", longint'(perr), m_err);
    chk((m_int == IMAX || m_int == IMIN) ? "R5 integ_o" : "R4 integ_o",
        longint'(integ), m_int);
  endtask

  task automatic start(input int nom, input int kp, input int ki, input int pin);
    @(negedge clk);
    rst_ni = 1'b0;
    nominal = ACC_W'(nom); kp_sh = SHIFT_W'(kp); ki_sh = SHIFT_W'(ki);
    phase_in = ACC_W'(pin);
    repeat (2) begin
      @(negedge clk);
      // R7 reset state
      chk("R7 phase_o", longint'(phase), 0);
      chk("R7 wrap_o", longint'(wrap), 0);
      chk("R7 perr_o", longint'(perr), 0);
      chk("R7 integ_o", longint'(integ), 0);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 first step equals nominal", longint'(phase), longint'(nom) == 0 ? 1 : longint'(nom));
    cmp_all();
  endtask

  initial begin
    // sweep gains and two input patterns: fixed phase, and a ramp (frequency offset)
    for (int ki = 2; ki <= 8; ki += 2) begin
      for (int kp = 0; kp <= 4; kp += 2) begin
        for (int pat = 0; pat < 2; pat++) begin
          start(300, kp, ki, 700);
          for (int c = 0; c < 400; c++) begin
            if (pat == 1) phase_in = phase_in + ACC_W'(37);
            @(negedge clk);
            cmp_all();
          end
        end
      end
    end

    // R5: forced error +1500 every update with ki=0 drives integrator to the top limit
    start(16, 15, 0, 0);
    for (int c = 0; c < 300; c++) begin
      phase_in = ACC_W'((m_ph + m_steer() + 1500) % MOD);
      @(negedge clk);
      cmp_all();
    end
    chk("R5 integrator saturated high", longint'(integ), IMAX);

    // R2: large negative error clamps the step to its minimum of 1
    start(4095, 0, 0, 0);
    for (int c = 0; c < 20; c++) begin
      phase_in = ACC_W'((m_ph + m_steer() + MOD - 2000) % MOD);
      @(negedge clk);
      cmp_all();
    end
    begin
      longint p0;
      p0 = longint'(phase);
      @(negedge clk);
      cmp_all();
      chk("R2 step clamped to 1", (longint'(phase) - p0 + MOD) % MOD, 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule